// File: doc/BRIEF.md
# Split-Array Compressed Word Store Controller

This block owns the data array of a power-aware compressed cache and sequences every access to it. Each 32-bit word slot is stored in two narrow arrays. The low array holds a format flag plus as many bits as a dictionary index needs. The high array holds the remaining upper bits. A slot in encoded form keeps only a dictionary index in the low array. A slot in raw form keeps the least significant index-width bits of the word in the low array and the upper bits in the high array.

A read looks at the low array first. If the flag marks the slot as encoded, the index goes out on the dictionary decode port and the decoded value comes back one cycle after acceptance, and the high array is never touched. If the slot is raw, the controller spends a second cycle on the high array and assembles the word. Compression is decided only when a line is filled, and a fill carries the dictionary verdict with it. A store into cached data can keep an encoded slot encoded by giving a new index. It never turns a raw slot into an encoded one. A store of a value that is not in the dictionary onto an encoded slot expands the whole line to raw form, one word per cycle, and the block reports busy while it does so.

Fill, store and read requests are valid/ready streams, and the read response is a valid/ready stream as well. A request transfers on a clock edge where both valid and ready are high. Fill has priority over store, and store has priority over read. One read is in flight at a time: a new read is refused while a response is waiting. The response holds its data stable until the consumer takes it. Tag lookup and replacement are done by the cache around this block.

Top module: `split_word_reader`

## Requirements
- R1: During and right after reset, rsp_valid, busy, hi_en and dict_rd_en are low. Every slot reads back as raw form with value zero, and fill_ready is high once reset is released.
- R2: An accepted fill with fill_enc=1 marks the slot encoded and stores fill_idx. It asserts hi_en in no cycle.
- R3: An accepted fill with fill_enc=0 stores fill_data in raw form. Bits [IDX_W-1:0] go to the low array and the upper bits go to the high array. hi_en is high for exactly the acceptance cycle.
- R4: A read of an encoded slot drives dict_rd_en=1 and dict_rd_idx=stored index in its acceptance cycle, with hi_en low. The response appears in the next cycle with rsp_data=dict_rd_value and rsp_enc=1.
- R5: A read of a raw slot asserts hi_en in exactly one cycle, the one after acceptance. The response appears two cycles after acceptance with the original 32-bit word and rsp_enc=0.
- R6: While rsp_valid is high and rsp_ready is low, rsp_valid and rsp_data stay unchanged. rd_ready stays low while any response is pending.
- R7: A store with wr_enc=1 onto an encoded slot replaces the stored index with wr_idx. The slot stays encoded and the high array is not accessed.
- R8: A store onto a raw slot writes wr_data in raw form even when wr_enc=1. The slot then reads with two-cycle latency and rsp_enc=0.
- R9: A store with wr_enc=0 onto an encoded slot holds busy for exactly WORDS cycles. It rewrites every other encoded word of the line in raw form with its decoded value and writes wr_data raw into the target. hi_en fires once per rewritten word plus once for the target.
- R10: When several requests are valid together, only fill_ready is high if fill_valid is set. Otherwise only wr_ready is high if wr_valid is set. rd_ready can be high only when neither fill_valid nor wr_valid is set.
- R11: While busy is high, fill_ready, wr_ready and rd_ready are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | Fill word request valid |
| fill_ready | output | 1 | Fill accepted on this edge when valid |
| fill_line | input | log2(LINES) | Fill line index |
| fill_word | input | log2(WORDS) | Fill word within line |
| fill_enc | input | 1 | Fill word is a dictionary hit |
| fill_idx | input | log2(DICT_N) | Dictionary index of the fill word |
| fill_data | input | 32 | Raw fill word |
| wr_valid | input | 1 | Store request valid |
| wr_ready | output | 1 | Store accepted on this edge when valid |
| wr_line | input | log2(LINES) | Store line index |
| wr_word | input | log2(WORDS) | Store word within line |
| wr_enc | input | 1 | Store value is a dictionary hit |
| wr_idx | input | log2(DICT_N) | Dictionary index of the store value |
| wr_data | input | 32 | Raw store value |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read accepted on this edge when valid |
| rd_line | input | log2(LINES) | Read line index |
| rd_word | input | log2(WORDS) | Read word within line |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Read word |
| rsp_enc | output | 1 | Response came from an encoded slot |
| dict_rd_en | output | 1 | Dictionary decode request |
| dict_rd_idx | output | log2(DICT_N) | Index to decode |
| dict_rd_value | input | 32 | Decoded value, same cycle |
| hi_en | output | 1 | High array read or write in this cycle |
| busy | output | 1 | Line expansion in progress |

## Verification
The bench fills lines that mix encoded and raw slots, then targets the timing split. If a design read the high array for encoded slots, the hi_en count rises. If it answered raw slots in one cycle, the latency measure shows that. Stores cover the three outcomes: index replacement on an encoded slot, forced raw storage of a dictionary hit on a raw slot, and line expansion. A design that skipped a neighbour during expansion, or expanded for the wrong number of cycles, returns a stale or wrongly decoded word, or shows a wrong busy length. The bench also stalls the response to catch data that moves or a second read that is let in, and it raises all three requests together to catch a wrong priority order.

// File: rtl/sw_pkg.sv
`timescale 1ns/1ps
package sw_pkg;
  localparam int WORD_BITS = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HIGH  = 2'd1,
    ST_SPLIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sw_bank.sv
`timescale 1ns/1ps
module sw_bank #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/sw_ctrl.sv
`timescale 1ns/1ps
module sw_ctrl
  import sw_pkg::*;
#(
  parameter int LINES = 16,
  parameter int WORDS = 4,
  parameter int IDX_W = 4,
  localparam int LINE_W = $clog2(LINES),
  localparam int WORD_W = $clog2(WORDS),
  localparam int ADDR_W = LINE_W + WORD_W,
  localparam int HI_W   = WORD_BITS - IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fill_valid,
  output logic                 fill_ready,
  input  logic [LINE_W-1:0]    fill_line,
  input  logic [WORD_W-1:0]    fill_word,
  input  logic                 fill_enc,
  input  logic [IDX_W-1:0]     fill_idx,
  input  logic [WORD_BITS-1:0] fill_data,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [LINE_W-1:0]    wr_line,
  input  logic [WORD_W-1:0]    wr_word,
  input  logic                 wr_enc,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [WORD_BITS-1:0] wr_data,
  input  logic                 rd_valid,
  output logic                 rd_ready,
  input  logic [LINE_W-1:0]    rd_line,
  input  logic [WORD_W-1:0]    rd_word,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [WORD_BITS-1:0] rsp_data,
  output logic                 rsp_enc,
  output logic                 dict_rd_en,
  output logic [IDX_W-1:0]     dict_rd_idx,
  input  logic [WORD_BITS-1:0] dict_rd_value,
  output logic                 hi_en,
  output logic                 busy,
  output logic                 lo_we,
  output logic [ADDR_W-1:0]    lo_waddr,
  output logic [IDX_W:0]       lo_wdata,
  output logic [ADDR_W-1:0]    lo_raddr,
  input  logic [IDX_W:0]       lo_rdata,
  output logic                 hi_we,
  output logic [ADDR_W-1:0]    hi_waddr,
  output logic [HI_W-1:0]      hi_wdata,
  output logic [ADDR_W-1:0]    hi_raddr,
  input  logic [HI_W-1:0]      hi_rdata
);
  seq_state_e st_q;
  logic [ADDR_W-1:0]    rd_addr_q;
  logic [IDX_W-1:0]     lo_keep_q;
  logic [LINE_W-1:0]    sp_line_q;
  logic [WORD_W-1:0]    sp_tgt_q;
  logic [WORD_W-1:0]    sp_ptr_q;
  logic [WORD_BITS-1:0] sp_data_q;

  logic idle, fill_fire, wr_fire, rd_fire, lo_flag, wr_split;
  logic [IDX_W-1:0] lo_bits;

  assign idle       = (st_q == ST_IDLE);
  assign busy       = (st_q == ST_SPLIT);
  assign fill_ready = idle;
  assign wr_ready   = idle && !fill_valid;
  assign rd_ready   = idle && !fill_valid && !wr_valid && !rsp_valid;
  assign fill_fire  = fill_valid && fill_ready;
  assign wr_fire    = wr_valid && wr_ready;
  assign rd_fire    = rd_valid && rd_ready;

  always_comb begin
    if (busy)          lo_raddr = {sp_line_q, sp_ptr_q};
    else if (wr_valid) lo_raddr = {wr_line, wr_word};
    else               lo_raddr = {rd_line, rd_word};
  end

  assign lo_flag  = lo_rdata[IDX_W];
  assign lo_bits  = lo_rdata[IDX_W-1:0];
  assign wr_split = wr_fire && lo_flag && !wr_enc;
  assign hi_raddr = rd_addr_q;
  assign dict_rd_idx = lo_bits;

  // Array write steering and dictionary use for every state
  always_comb begin
    lo_we      = 1'b0;
    lo_waddr   = '0;
    lo_wdata   = '0;
    hi_we      = 1'b0;
    hi_waddr   = '0;
    hi_wdata   = '0;
    dict_rd_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (fill_fire) begin
          lo_we    = 1'b1;
          lo_waddr = {fill_line, fill_word};
          if (fill_enc) begin
            lo_wdata = {1'b1, fill_idx};
          end else begin
            lo_wdata = {1'b0, fill_data[IDX_W-1:0]};
            hi_we    = 1'b1;
            hi_waddr = {fill_line, fill_word};
            hi_wdata = fill_data[WORD_BITS-1:IDX_W];
          end
        end else if (wr_fire) begin
          if (lo_flag && wr_enc) begin
            lo_we    = 1'b1;
            lo_waddr = {wr_line, wr_word};
            lo_wdata = {1'b1, wr_idx};
          end else if (!lo_flag) begin
            lo_we    = 1'b1;
            lo_waddr = {wr_line, wr_word};
            lo_wdata = {1'b0, wr_data[IDX_W-1:0]};
            hi_we    = 1'b1;
            hi_waddr = {wr_line, wr_word};
            hi_wdata = wr_data[WORD_BITS-1:IDX_W];
          end
        end else if (rd_fire && lo_flag) begin
          dict_rd_en = 1'b1;
        end
      end
      ST_SPLIT: begin
        if (sp_ptr_q == sp_tgt_q) begin
          lo_we    = 1'b1;
          lo_waddr = {sp_line_q, sp_ptr_q};
          lo_wdata = {1'b0, sp_data_q[IDX_W-1:0]};
          hi_we    = 1'b1;
          hi_waddr = {sp_line_q, sp_ptr_q};
          hi_wdata = sp_data_q[WORD_BITS-1:IDX_W];
        end else if (lo_flag) begin
          dict_rd_en = 1'b1;
          lo_we    = 1'b1;
          lo_waddr = {sp_line_q, sp_ptr_q};
          lo_wdata = {1'b0, dict_rd_value[IDX_W-1:0]};
          hi_we    = 1'b1;
          hi_waddr = {sp_line_q, sp_ptr_q};
          hi_wdata = dict_rd_value[WORD_BITS-1:IDX_W];
        end
      end
      default: ;
    endcase
  end

  assign hi_en = hi_we || (st_q == ST_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      rd_addr_q <= '0;
      lo_keep_q <= '0;
      sp_line_q <= '0;
      sp_tgt_q  <= '0;
      sp_ptr_q  <= '0;
      sp_data_q <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_enc   <= 1'b0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (rd_fire) begin
            if (lo_flag) begin
              rsp_valid <= 1'b1;
              rsp_data  <= dict_rd_value;
              rsp_enc   <= 1'b1;
            end else begin
              rd_addr_q <= {rd_line, rd_word};
              lo_keep_q <= lo_bits;
              st_q      <= ST_HIGH;
            end
          end else if (wr_split) begin
            sp_line_q <= wr_line;
            sp_tgt_q  <= wr_word;
            sp_data_q <= wr_data;
            sp_ptr_q  <= '0;
            st_q      <= ST_SPLIT;
          end
        end
        ST_HIGH: begin
          rsp_valid <= 1'b1;
          rsp_data  <= {hi_rdata, lo_keep_q};
          rsp_enc   <= 1'b0;
          st_q      <= ST_IDLE;
        end
        ST_SPLIT: begin
          sp_ptr_q <= sp_ptr_q + WORD_W'(1);
          if (sp_ptr_q == WORD_W'(WORDS - 1)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Length of the current expansion run, used only by the check below
  logic [WORD_W:0] split_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    split_run_q <= '0;
    else if (busy) split_run_q <= split_run_q + (WORD_W+1)'(1);
    else           split_run_q <= '0;
  end

  assert_enc_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && lo_flag) |=> (rsp_valid && rsp_enc));

  assert_enc_no_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && lo_flag) |-> (dict_rd_en && !hi_en));

  assert_raw_two_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !lo_flag) |=> (hi_en && !rsp_valid) ##1 (rsp_valid && !rsp_enc));

  assert_rsp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_single_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !rd_ready);

  assert_split_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (split_run_q == (WORD_W+1)'(WORDS)));
endmodule

// File: rtl/split_word_reader.sv
`timescale 1ns/1ps
module split_word_reader
  import sw_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int DICT_N = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fill_valid,
  output logic                       fill_ready,
  input  logic [$clog2(LINES)-1:0]   fill_line,
  input  logic [$clog2(WORDS)-1:0]   fill_word,
  input  logic                       fill_enc,
  input  logic [$clog2(DICT_N)-1:0]  fill_idx,
  input  logic [31:0]                fill_data,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [$clog2(LINES)-1:0]   wr_line,
  input  logic [$clog2(WORDS)-1:0]   wr_word,
  input  logic                       wr_enc,
  input  logic [$clog2(DICT_N)-1:0]  wr_idx,
  input  logic [31:0]                wr_data,
  input  logic                       rd_valid,
  output logic                       rd_ready,
  input  logic [$clog2(LINES)-1:0]   rd_line,
  input  logic [$clog2(WORDS)-1:0]   rd_word,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [31:0]                rsp_data,
  output logic                       rsp_enc,
  output logic                       dict_rd_en,
  output logic [$clog2(DICT_N)-1:0]  dict_rd_idx,
  input  logic [31:0]                dict_rd_value,
  output logic                       hi_en,
  output logic                       busy
);
  localparam int IDX_W  = $clog2(DICT_N);
  localparam int DEPTH  = LINES * WORDS;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int HI_W   = WORD_BITS - IDX_W;

  logic              lo_we, hi_we;
  logic [ADDR_W-1:0] lo_waddr, lo_raddr, hi_waddr, hi_raddr;
  logic [IDX_W:0]    lo_wdata, lo_rdata;
  logic [HI_W-1:0]   hi_wdata, hi_rdata;

  sw_ctrl #(.LINES(LINES), .WORDS(WORDS), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_line(fill_line),
    .fill_word(fill_word), .fill_enc(fill_enc), .fill_idx(fill_idx), .fill_data(fill_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_line(wr_line), .wr_word(wr_word),
    .wr_enc(wr_enc), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_line(rd_line), .rd_word(rd_word),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_enc(rsp_enc),
    .dict_rd_en(dict_rd_en), .dict_rd_idx(dict_rd_idx), .dict_rd_value(dict_rd_value),
    .hi_en(hi_en), .busy(busy),
    .lo_we(lo_we), .lo_waddr(lo_waddr), .lo_wdata(lo_wdata), .lo_raddr(lo_raddr),
    .lo_rdata(lo_rdata),
    .hi_we(hi_we), .hi_waddr(hi_waddr), .hi_wdata(hi_wdata), .hi_raddr(hi_raddr),
    .hi_rdata(hi_rdata)
  );

  sw_bank #(.WIDTH(IDX_W + 1), .DEPTH(DEPTH)) low_bank_i (
    .clk(clk), .rst_n(rst_n), .we(lo_we), .waddr(lo_waddr), .wdata(lo_wdata),
    .raddr(lo_raddr), .rdata(lo_rdata)
  );

  sw_bank #(.WIDTH(HI_W), .DEPTH(DEPTH)) high_bank_i (
    .clk(clk), .rst_n(rst_n), .we(hi_we), .waddr(hi_waddr), .wdata(hi_wdata),
    .raddr(hi_raddr), .rdata(hi_rdata)
  );
endmodule

// File: tb/split_word_reader_tb_top.sv
`timescale 1ns/1ps
module split_word_reader_tb_top;
  localparam int LINES = 16, WORDS = 4, DICT_N = 16, IDX_W = 4;
  localparam int LW = $clog2(LINES), WW = $clog2(WORDS);

  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst_n;

  logic fill_valid, fill_ready, fill_enc;
  logic [LW-1:0] fill_line; logic [WW-1:0] fill_word;
  logic [IDX_W-1:0] fill_idx; logic [31:0] fill_data;
  logic wr_valid, wr_ready, wr_enc;
  logic [LW-1:0] wr_line; logic [WW-1:0] wr_word;
  logic [IDX_W-1:0] wr_idx; logic [31:0] wr_data;
  logic rd_valid, rd_ready;
  logic [LW-1:0] rd_line; logic [WW-1:0] rd_word;
  logic rsp_valid, rsp_ready, rsp_enc;
  logic [31:0] rsp_data;
  logic dict_rd_en; logic [IDX_W-1:0] dict_rd_idx; logic [31:0] dict_rd_value;
  logic hi_en, busy;

  function automatic logic [31:0] dict_of(input logic [IDX_W-1:0] i);
    return 32'h9E37_0050 ^ ({28'd0, i} * 32'h0103_0207);
  endfunction
  assign dict_rd_value = dict_of(dict_rd_idx);

  split_word_reader #(.LINES(LINES), .WORDS(WORDS), .DICT_N(DICT_N)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_line(fill_line),
    .fill_word(fill_word), .fill_enc(fill_enc), .fill_idx(fill_idx), .fill_data(fill_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_line(wr_line), .wr_word(wr_word),
    .wr_enc(wr_enc), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_line(rd_line), .rd_word(rd_word),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_enc(rsp_enc),
    .dict_rd_en(dict_rd_en), .dict_rd_idx(dict_rd_idx), .dict_rd_value(dict_rd_value),
    .hi_en(hi_en), .busy(busy)
  );

  // Reference contents
  logic [31:0]      m_val [LINES*WORDS];
  bit               m_enc [LINES*WORDS];
  logic [IDX_W-1:0] m_idx [LINES*WORDS];

  // Scoreboard
  logic [31:0] q_data[$];
  bit          q_enc[$];
  bit          q_lat[$];
  int          q_acc[$];

  int cyc = 0, n_chk = 0, n_fail = 0, hi_cnt = 0, busy_cnt = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: samples 1 ns before each rising edge
  always @(posedge clk) begin : mon
    logic [31:0] d; bit e; bit l; int a;
    #3;
    if (rst_n === 1'b1) begin
      if (hi_en) hi_cnt++;
      if (busy) busy_cnt++;
      if (rsp_valid && rsp_ready) begin
        if (q_data.size() == 0) chk(1'b0, "R6 unexpected response", rsp_data, 32'h0);
        else begin
          d = q_data.pop_front(); e = q_enc.pop_front();
          l = q_lat.pop_front(); a = q_acc.pop_front();
          chk(rsp_data === d, e ? "R4 decoded data" : "R5 assembled data", rsp_data, d);
          chk(rsp_enc === e, e ? "R4 rsp_enc" : "R5 rsp_enc", {31'd0, rsp_enc}, {31'd0, e});
          if (l) chk((cyc - a + 1) == (e ? 1 : 2), e ? "R4 latency" : "R5 latency",
                     32'(cyc - a + 1), e ? 32'd1 : 32'd2);
        end
      end
    end
  end

  function automatic logic [31:0] expect_of(input int t);
    return m_enc[t] ? dict_of(m_idx[t]) : m_val[t];
  endfunction

  task automatic do_fill(input int ln, input int wd, input bit enc, input int idx, input logic [31:0] data);
    int h0; int t;
    t = ln * WORDS + wd;
    @(posedge clk); #1;
    fill_valid = 1; fill_line = LW'(ln); fill_word = WW'(wd);
    fill_enc = enc; fill_idx = IDX_W'(idx); fill_data = data;
    #1;
    while (!fill_ready) begin @(posedge clk); #2; end
    h0 = hi_cnt;
    @(posedge clk); #1; fill_valid = 0; #1;
    m_enc[t] = enc; m_idx[t] = IDX_W'(idx); m_val[t] = data;
    chk(hi_cnt - h0 == (enc ? 0 : 1), enc ? "R2 no high access" : "R3 one high write",
        32'(hi_cnt - h0), enc ? 32'd0 : 32'd1);
  endtask

  task automatic do_read(input int ln, input int wd, input int hold);
    int h0; int t; bit en; logic [31:0] e;
    t = ln * WORDS + wd; en = m_enc[t]; e = expect_of(t);
    @(posedge clk); #1;
    rd_valid = 1; rd_line = LW'(ln); rd_word = WW'(wd);
    if (hold > 0) rsp_ready = 0;
    #1;
    while (!rd_ready) begin @(posedge clk); #2; end
    chk(dict_rd_en === en, en ? "R4 dict_rd_en" : "R5 dict_rd_en", {31'd0, dict_rd_en}, {31'd0, en});
    if (en) chk(dict_rd_idx === m_idx[t], "R4 dict_rd_idx", {28'd0, dict_rd_idx}, {28'd0, m_idx[t]});
    h0 = hi_cnt;
    q_data.push_back(e); q_enc.push_back(en); q_lat.push_back(hold == 0); q_acc.push_back(cyc + 1);
    @(posedge clk); #1; rd_valid = 0;
    if (hold > 0) begin
      repeat (2) @(posedge clk);
      for (int k = 0; k < hold; k++) begin
        #1;
        chk(rsp_valid === 1'b1 && rsp_data === e, "R6 held response", rsp_data, e);
        chk(rd_ready === 1'b0, "R6 rd_ready while pending", {31'd0, rd_ready}, 32'd0);
        @(posedge clk);
      end
      #1; rsp_ready = 1;
    end
    #1;
    while (q_data.size() != 0) begin @(posedge clk); #2; end
    chk(hi_cnt - h0 == (en ? 0 : 1), en ? "R4 high array untouched" : "R5 one high read",
        32'(hi_cnt - h0), en ? 32'd0 : 32'd1);
  endtask

  task automatic do_write(input int ln, input int wd, input bit enc, input int idx,
                          input logic [31:0] data, input string tag);
    int h0, b0, t, exp_hi, exp_busy; bit seen;
    t = ln * WORDS + wd;
    if (m_enc[t] && enc) begin
      exp_hi = 0; exp_busy = 0; m_idx[t] = IDX_W'(idx);
    end else if (!m_enc[t]) begin
      exp_hi = 1; exp_busy = 0; m_val[t] = data;
    end else begin
      exp_hi = 1; exp_busy = WORDS;
      for (int w = 0; w < WORDS; w++) begin
        if (w != wd && m_enc[ln*WORDS + w]) begin
          exp_hi++;
          m_val[ln*WORDS + w] = dict_of(m_idx[ln*WORDS + w]);
          m_enc[ln*WORDS + w] = 0;
        end
      end
      m_val[t] = data; m_enc[t] = 0;
    end
    @(posedge clk); #1;
    wr_valid = 1; wr_line = LW'(ln); wr_word = WW'(wd);
    wr_enc = enc; wr_idx = IDX_W'(idx); wr_data = data;
    #1;
    while (!wr_ready) begin @(posedge clk); #2; end
    h0 = hi_cnt; b0 = busy_cnt;
    @(posedge clk); #1; wr_valid = 0; #1;
    seen = 0;
    while (busy) begin
      if (!seen) begin
        seen = 1;
        chk(!fill_ready && !wr_ready && !rd_ready, "R11 ready low while busy",
            {29'd0, fill_ready, wr_ready, rd_ready}, 32'd0);
      end
      @(posedge clk); #2;
    end
    @(posedge clk); #2;
    chk(busy_cnt - b0 == exp_busy, {tag, " busy length"}, 32'(busy_cnt - b0), 32'(exp_busy));
    chk(hi_cnt - h0 == exp_hi, {tag, " high access count"}, 32'(hi_cnt - h0), 32'(exp_hi));
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 0;
    fill_valid = 0; wr_valid = 0; rd_valid = 0; rsp_ready = 1;
    fill_line = '0; fill_word = '0; fill_enc = 0; fill_idx = '0; fill_data = '0;
    wr_line = '0; wr_word = '0; wr_enc = 0; wr_idx = '0; wr_data = '0;
    rd_line = '0; rd_word = '0;
    for (int i = 0; i < LINES*WORDS; i++) begin m_val[i] = '0; m_enc[i] = 0; m_idx[i] = '0; end
    repeat (3) @(posedge clk);
    #3;
    chk(!rsp_valid && !busy && !hi_en && !dict_rd_en, "R1 reset outputs",
        {28'd0, rsp_valid, busy, hi_en, dict_rd_en}, 32'd0);
    @(posedge clk); #1; rst_n = 1; #1;
    chk(fill_ready === 1'b1, "R1 fill_ready after reset", {31'd0, fill_ready}, 32'd1);

    // R1: untouched slot reads zero in raw form
    do_read(0, 0, 0);

    // R2, R3: fills with mixed formats
    do_fill(1, 0, 1, 3, 32'h0);
    do_fill(1, 1, 0, 0, 32'h1234_5678);
    do_fill(1, 2, 1, 15, 32'h0);
    do_fill(1, 3, 0, 0, 32'hCAFE_F00D);
    for (int w = 0; w < WORDS; w++) do_fill(2, w, 1, (w * 7 + 1) % DICT_N, 32'h0);
    for (int w = 0; w < WORDS; w++) do_fill(3, w, 0, 0, 32'hA000_0000 + 32'(w * 32'h1111_0001));

    // R4, R5: reads of every filled slot
    for (int ln = 1; ln <= 3; ln++)
      for (int w = 0; w < WORDS; w++) do_read(ln, w, 0);

    // R7: dictionary hit written over an encoded slot
    do_write(2, 1, 1, 5, 32'hDEAD_0000, "R7");
    do_read(2, 1, 0);
    // R8: dictionary hit written over a raw slot stays raw
    do_write(1, 1, 1, 4, 32'h0BAD_BEEF, "R8");
    do_read(1, 1, 0);

    // R6: response stalled by the consumer
    do_read(3, 2, 4);
    do_read(2, 3, 3);

    // R9: non-frequent store onto an encoded slot expands the line
    do_write(2, 2, 0, 0, 32'h7777_1234, "R9");
    for (int w = 0; w < WORDS; w++) do_read(2, w, 0);
    do_write(1, 0, 0, 0, 32'h5555_AAAA, "R9");
    for (int w = 0; w < WORDS; w++) do_read(1, w, 0);
    // R8: dictionary hit onto a slot that expansion made raw
    do_write(2, 0, 1, 9, 32'h0102_0304, "R8");
    do_read(2, 0, 0);

    // R10: all three requests raised together
    @(posedge clk); #1;
    fill_valid = 1; fill_line = LW'(5); fill_word = '0; fill_enc = 0; fill_data = 32'h3141_5926;
    wr_valid = 1; wr_line = LW'(3); wr_word = '0; wr_enc = 0; wr_data = 32'h2718_2818;
    rd_valid = 1; rd_line = LW'(3); rd_word = WW'(1);
    #1;
    chk(fill_ready && !wr_ready && !rd_ready, "R10 fill wins",
        {29'd0, fill_ready, wr_ready, rd_ready}, 32'd4);
    @(posedge clk); #1; fill_valid = 0; #1;
    m_val[5*WORDS] = 32'h3141_5926; m_enc[5*WORDS] = 0;
    chk(wr_ready && !rd_ready, "R10 store before read", {30'd0, wr_ready, rd_ready}, 32'd2);
    @(posedge clk); #1; wr_valid = 0; rd_valid = 0;
    m_val[3*WORDS] = 32'h2718_2818; m_enc[3*WORDS] = 0;
    do_read(5, 0, 0);
    do_read(3, 0, 0);

    repeat (4) @(posedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule